// File: doc/BRIEF.md
# Iterative Peak Cancellation Engine

This block sits after the inverse transform of a multitone transmitter and lowers the crest factor of each time-domain symbol. A symbol of `N` real samples is streamed in and held in a local buffer. Each pass scans the whole buffer for the single largest magnitude that lies above a programmable threshold. It then subtracts a scaled, cyclically shifted copy of a stored cancellation waveform from every sample. The waveform is built offline from tones that carry no data, so the subtraction disturbs only unused tones. The corrected symbol then streams out in its original sample order.

A bypass flag travels with the first sample of each symbol, and a set flag passes that symbol through untouched. The number of passes per symbol comes from a configuration input. A pass that finds no sample over the threshold ends processing early. The cancellation waveform lives in a small memory that has its own write port and is stored with its main lobe at index 0.

Top module: `peak_cancel`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: The block accepts exactly `N` input samples per symbol. `in_ready` then stays low until all `N` output samples have been handed over, and `in_ready` and `out_valid` are never high together.
- R3: `in_bypass` is sampled with the first sample of a symbol; when it is 1 the output equals the input and `out_valid` rises in the cycle after the last input handshake. `in_bypass` on the other samples is ignored.
- R4: A pass selects the sample of largest magnitude that is strictly greater than `cfg_thresh`; of several with equal magnitude the one with the lowest index wins.
- R5: The scale of a pass is the signed peak minus `cfg_thresh` carrying the peak's sign. Kernel words are signed with 14 fraction bits (16384 is 1.0), and each product is rounded by adding 8192 and shifting right arithmetically by 14.
- R6: In a pass with peak index p, sample n has the kernel word at index (n - p) mod N subtracted; `N` is a power of two.
- R7: Each corrected sample saturates to the signed `DW`-bit range.
- R8: At most `cfg_iters` passes are made per symbol; with `cfg_iters` = 0 the symbol leaves unchanged after zero extra cycles.
- R9: A scan takes `N` cycles and a subtraction `N` cycles; a scan that finds no sample above the threshold sends the symbol at once, so the gap from last input to first output is N per scan plus N per subtraction.
- R10: Output samples leave in index order, and `out_data` holds steady while `out_valid` is high and `out_ready` low.
- R11: A write with `kern_we` = 1 stores `kern_wdata` at `kern_addr`, and symbols processed afterwards use the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | DW-1 | Magnitude threshold, unsigned |
| cfg_iters | input | IW | Maximum passes per symbol |
| kern_we | input | 1 | Kernel memory write enable |
| kern_addr | input | log2(N) | Kernel memory write address |
| kern_wdata | input | KW | Kernel word, signed fixed point |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | DW | Input sample, signed |
| in_bypass | input | 1 | Pass-through flag, read with the first sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output sample |
| out_data | output | DW | Output sample, signed |

## Verification
The bench builds the block with a 16-sample symbol, 16-bit samples and kernel words, and a 3-bit pass count. The short symbol keeps a seven-pass symbol to about 240 cycles, so dozens of random symbols fit in the run. The 3-bit count reaches its full range, and 16-bit samples let the magnitude of the most negative sample and a saturating sum both appear. Directed symbols add a magnitude tie with opposite signs, an empty scan, a zero pass count and a kernel rewritten between symbols.

// File: rtl/peak_cancel.sv
module peak_cancel #(
  parameter int N     = 64,
  parameter int DW    = 16,
  parameter int KW    = 16,
  parameter int KFRAC = 14,
  parameter int IW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-2:0]        cfg_thresh,
  input  logic [IW-1:0]        cfg_iters,
  input  logic                 kern_we,
  input  logic [$clog2(N)-1:0] kern_addr,
  input  logic [KW-1:0]        kern_wdata,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DW-1:0]        in_data,
  input  logic                 in_bypass,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_data
);
  localparam int AW = $clog2(N);
  localparam int PW = DW + KW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (KFRAC - 1);
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

  typedef enum logic [1:0] {S_LOAD, S_SCAN, S_SUB, S_SEND} st_t;
  st_t st;

  logic        [DW-1:0] sbuf [N];
  logic signed [KW-1:0] kmem [N];
  logic [AW-1:0] idx, pk_idx;
  logic [IW-1:0] itc;
  logic [DW-1:0] pk_mag;
  logic signed [DW-1:0] pk_val;
  logic byp;

  logic scan_ph, sub_ph, last, take, found_any, byp_now;
  logic signed [DW-1:0] cur;
  logic [DW-1:0] cur_mag, res;
  logic [IW-1:0] itc_n;
  logic signed [DW:0] thr_s, pk_ext, scale;
  logic signed [KW-1:0] kval;
  logic signed [PW-1:0] prod, rnd;
  logic signed [PW:0] diff;

  assign scan_ph   = st == S_SCAN;
  assign sub_ph    = st == S_SUB;
  assign last      = idx == AW'(N - 1);
  assign cur       = sbuf[idx];
  assign cur_mag   = cur[DW-1] ? DW'(-cur) : cur;
  assign take      = scan_ph && (cur_mag > pk_mag);
  assign found_any = take || (pk_mag != {1'b0, cfg_thresh});
  assign byp_now   = (idx == '0) ? in_bypass : byp;
  assign itc_n     = itc + 1'b1;

  assign thr_s  = {2'b00, cfg_thresh};
  assign pk_ext = {pk_val[DW-1], pk_val};
  assign scale  = pk_val[DW-1] ? pk_ext + thr_s : pk_ext - thr_s;
  assign kval   = kmem[idx - pk_idx];
  assign prod   = scale * kval;
  assign rnd    = (prod + HALF) >>> KFRAC;
  assign diff   = {{(KW+2){cur[DW-1]}}, cur} - {rnd[PW-1], rnd};
  assign res    = (&diff[PW:DW-1] || ~|diff[PW:DW-1]) ? diff[DW-1:0]
                : (diff[PW] ? SMIN : SMAX);

  assign in_ready  = st == S_LOAD;
  assign out_valid = st == S_SEND;
  assign out_data  = cur;

  always_ff @(posedge clk) begin
    if (kern_we) kmem[kern_addr] <= kern_wdata;
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) sbuf[idx] <= in_data;
    else if (sub_ph)          sbuf[idx] <= res;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_LOAD;
      idx    <= '0;
      itc    <= '0;
      pk_mag <= '0;
      pk_val <= '0;
      pk_idx <= '0;
      byp    <= 1'b0;
    end else begin
      case (st)
        S_LOAD: if (in_valid) begin
          idx <= idx + 1'b1;
          if (idx == '0) byp <= in_bypass;
          if (last) begin
            itc    <= '0;
            pk_mag <= {1'b0, cfg_thresh};
            st     <= (byp_now || cfg_iters == '0) ? S_SEND : S_SCAN;
          end
        end
        S_SCAN: begin
          idx <= idx + 1'b1;
          if (take) begin
            pk_mag <= cur_mag;
            pk_val <= cur;
            pk_idx <= idx;
          end
          if (last) st <= found_any ? S_SUB : S_SEND;
        end
        S_SUB: begin
          idx <= idx + 1'b1;
          if (last) begin
            itc    <= itc_n;
            pk_mag <= {1'b0, cfg_thresh};
            st     <= (itc_n == cfg_iters) ? S_SEND : S_SCAN;
          end
        end
        default: if (out_ready) begin
          idx <= idx + 1'b1;
          if (last) st <= S_LOAD;
        end
      endcase
    end
  end
endmodule

// File: rtl/peak_cancel_chk.sv
module peak_cancel_chk #(
  parameter int N  = 64,
  parameter int DW = 16,
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          sub_ph,
  input logic [DW-1:0] pk_mag,
  input logic [DW-2:0] cfg_thresh,
  input logic [IW-1:0] itc,
  input logic [IW-1:0] cfg_iters
);
  localparam int AW = $clog2(N);
  logic [AW-1:0] ocnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ocnt <= '0;
    else if (out_valid && out_ready) ocnt <= ocnt + 1'b1;
  end

  AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R2
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10
  AST_SYMBOL_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && ocnt == AW'(N - 1) |=> !out_valid); // R2
  AST_PASS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ph |-> itc < cfg_iters); // R8
  AST_PEAK_OVER_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    sub_ph |-> pk_mag > {1'b0, cfg_thresh}); // R4
endmodule

bind peak_cancel peak_cancel_chk #(.N(N), .DW(DW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .sub_ph(sub_ph), .pk_mag(pk_mag),
  .cfg_thresh(cfg_thresh), .itc(itc), .cfg_iters(cfg_iters)
);

// File: tb/tb_peak_cancel.sv
module tb_peak_cancel;
  localparam int N = 16, DW = 16, KW = 16, KFRAC = 14, IW = 3, AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-2:0] cfg_thresh = '0;
  logic [IW-1:0] cfg_iters = '0;
  logic kern_we = 1'b0;
  logic [AW-1:0] kern_addr = '0;
  logic [KW-1:0] kern_wdata = '0;
  logic in_valid = 1'b0, in_bypass = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  int sym [N];
  int kref [N];
  int expv [N];
  int exp_lat;

  always #4 clk = ~clk;

  peak_cancel #(.N(N), .DW(DW), .KW(KW), .KFRAC(KFRAC), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_iters(cfg_iters),
    .kern_we(kern_we), .kern_addr(kern_addr), .kern_wdata(kern_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_bypass(in_bypass), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input bit byp, input int iters, input int thr);
    for (int n = 0; n < N; n++) expv[n] = sym[n];
    exp_lat = 0;
    if (byp || iters == 0) return;
    for (int it = 0; it < iters; it++) begin
      int best = thr, p = -1, sc;
      for (int n = 0; n < N; n++) begin
        int m = expv[n] < 0 ? -expv[n] : expv[n];
        if (m > best) begin best = m; p = n; end
      end
      exp_lat += N;
      if (p < 0) break;
      sc = expv[p] < 0 ? expv[p] + thr : expv[p] - thr;
      for (int n = 0; n < N; n++) begin
        longint pr = longint'(sc) * kref[(n - p + N) % N];
        longint r  = (pr + (longint'(1) <<< (KFRAC - 1))) >>> KFRAC;
        longint d  = expv[n] - r;
        if (d > 32767) d = 32767;
        if (d < -32768) d = -32768;
        expv[n] = int'(d);
      end
      exp_lat += N;
    end
  endfunction

  task automatic load_kernel();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      kern_we = 1'b1; kern_addr = AW'(i); kern_wdata = KW'(kref[i]);
    end
    @(negedge clk);
    kern_we = 1'b0;
  endtask

  task automatic run_symbol(input bit byp, input int iters, input int thr, input string req);
    int lat, cnt;
    model(byp, iters, thr);
    @(negedge clk);
    cfg_thresh = (DW-1)'(thr); cfg_iters = IW'(iters);
    for (int i = 0; i < N; i++) begin
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = DW'(sym[i]);
      in_bypass = (i == 0) ? byp : 1'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 in_ready after full symbol", in_ready, 0);
    lat = 0;
    while (!out_valid && lat < 400) begin @(negedge clk); lat++; end
    check(lat == exp_lat, {req, " R9 latency"}, lat, exp_lat);
    cnt = 0;
    while (cnt < N) begin
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        check($signed(out_data) == expv[cnt], {req, " sample"}, $signed(out_data), expv[cnt]);
        cnt++;
      end else if (!out_valid) begin
        check(1'b0, "R10 out_valid dropped mid-symbol", 0, 1);
        cnt++;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R2 ready for next symbol", {out_valid, in_ready}, 1);
  endtask

  function automatic void rand_sym(input int span);
    for (int n = 0; n < N; n++) sym[n] = int'($urandom % (2 * span + 1)) - span;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready at reset", in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid at reset", out_valid, 0);
    rst_n = 1'b1;

    for (int n = 0; n < N; n++) kref[n] = int'($urandom % 2001) - 1000;
    kref[0] = 16384; kref[1] = -8192; kref[N-1] = -8192;
    load_kernel();

    rand_sym(30000);
    run_symbol(1'b1, 3, 1000, "R3 bypass");
    rand_sym(30000);
    run_symbol(1'b0, 0, 1000, "R8 zero passes");
    rand_sym(500);
    run_symbol(1'b0, 3, 2000, "R9 empty scan");
    rand_sym(500); sym[3] = 12000; sym[9] = -12000;
    run_symbol(1'b0, 1, 4000, "R4 tie lowest index");
    rand_sym(500); sym[2] = -32768;
    run_symbol(1'b0, 1, 100, "R5 most negative peak");

    for (int n = 0; n < N; n++) kref[n] = 0;
    kref[0] = 16384; kref[1] = -16384;
    load_kernel();
    rand_sym(500); sym[5] = 30000; sym[6] = 20000;
    run_symbol(1'b0, 1, 1000, "R7 R11 saturation after kernel rewrite");
    rand_sym(500); sym[5] = -30000; sym[6] = -20000;
    run_symbol(1'b0, 1, 1000, "R7 negative saturation");

    for (int n = 0; n < N; n++) kref[n] = 0;
    kref[2] = 16384;
    load_kernel();
    rand_sym(300); sym[N-1] = 9000; sym[1] = 700;
    run_symbol(1'b0, 1, 1000, "R6 cyclic wrap");

    for (int s = 0; s < 24; s++) begin
      if (s % 6 == 0) begin
        for (int n = 0; n < N; n++) kref[n] = int'($urandom % 6001) - 3000;
        kref[0] = 16384;
        load_kernel();
      end
      rand_sym((s % 3 == 0) ? 32767 : 12000);
      run_symbol(($urandom % 5) == 0, int'($urandom % 8), int'($urandom % 20000),
                 "R4 R5 R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule